// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block is the receive front end of an I2C slave. It watches the SCL and SDA lines, which arrive already synchronised to the system clock. It recognises Start and Stop conditions and shifts in the first byte after every Start. That byte is compared with a programmable own address and, when general call is enabled, with the all-zero general call byte. Both 7-bit and 10-bit own addressing are supported.

A matched address is acknowledged by pulling SDA low during the ninth clock. After that the block receives data bytes, acknowledges each one and loads it into a one-byte receive buffer. Software consumes the buffer through a read strobe. It learns about each accepted byte from an interrupt pulse. It can tell a general call from its own address by reading the buffered address byte, or by looking at the general-call indication.

In 10-bit mode a matched header byte raises an update-address request, and a second address byte must then match the low eight address bits. A general call received in 10-bit mode skips that second byte: the request stays clear and data follows at once.

Top module: `i2c_am_top`

## Requirements
- R1: A Start (SDA falling while SCL is high) begins address reception. A Stop (SDA rising while SCL is high) returns the block to idle and releases SDA. SCL pulses that arrive after a Stop and before the next Start are never acknowledged.
- R2: In 7-bit mode (`addr_10bit`=0), the first byte matches when its bits 7:1 equal `own_addr[6:0]`, whatever the value of bit 0. A match is acknowledged by driving `sda_pull`=1 from the SCL falling edge after the eighth bit until the SCL falling edge that ends the ninth clock.
- R3: The first byte 8'h00 matches as a general call only while `gcall_en`=1. It is then acknowledged and sets `gcall_hit`=1, which stays set until the next Start or Stop. The byte 8'h01 is never a general call.
- R4: In 10-bit mode, the first byte matches when it equals {5'b11110, `own_addr[9:8]`, 1'b0}. A match is acknowledged and sets `upd_addr`=1. The next byte must equal `own_addr[7:0]` to be acknowledged. `upd_addr` clears when that byte completes, and also on a Start or Stop.
- R5: In 10-bit mode, a general call byte received with `gcall_en`=1 is acknowledged and leaves `upd_addr`=0. The byte that follows it is treated as data.
- R6: At the eighth SCL rising edge of a byte that is accepted, the received byte is loaded into `rx_buf` and `buf_full` is set. A one-cycle `buf_rd` pulse clears `buf_full`.
- R7: `irq` is a one-cycle pulse after the SCL falling edge that ends the ninth clock of each acknowledged byte. A byte that is not acknowledged gives no pulse.
- R8: If a byte that would be accepted completes while `buf_full`=1, `rx_ovf` is set and the byte is not acknowledged. `rx_buf` keeps its old value and the block returns to idle. `ovf_clr` clears `rx_ovf`.
- R9: A Start in the middle of a byte discards the partial byte and restarts address reception. A repeated Start after a completed byte does the same.
- R10: A first byte that matches nothing leaves SDA released and `buf_full` unchanged, and the block ignores the bus until the next Start.
- R11: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| own_addr | input | 10 | Own slave address (bits 6:0 used in 7-bit mode) |
| addr_10bit | input | 1 | 1 selects 10-bit addressing |
| gcall_en | input | 1 | 1 enables general call recognition |
| buf_rd | input | 1 | Read strobe, clears buf_full |
| ovf_clr | input | 1 | Clears rx_ovf |
| sda_pull | output | 1 | 1 requests SDA driven low (acknowledge) |
| rx_buf | output | 8 | Receive buffer |
| buf_full | output | 1 | Receive buffer holds an unread byte |
| rx_ovf | output | 1 | Receive overflow flag |
| irq | output | 1 | One-cycle interrupt pulse per accepted byte |
| upd_addr | output | 1 | 10-bit low address byte awaited |
| gcall_hit | output | 1 | Current transfer was addressed by general call |

## Verification
Every line change is seen by the condition detector on the first clock edge that samples it. Every result is registered on that same edge, so `rx_buf`, `buf_full`, `rx_ovf`, `upd_addr` and `gcall_hit` are due one cycle after the eighth SCL rise, and `sda_pull` and `irq` are due one cycle after the relevant SCL fall. The bench holds each SCL phase for four clocks, changes inputs on the falling clock edge, and samples two clocks after the edge that matters, so each output has settled and has not yet moved on. The interrupt pulse is counted by a free-running monitor, and its count is compared before and after each ninth clock.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 10;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [4:0] TENBIT_HDR = 5'b11110;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR1,
    ST_ADDR2,
    ST_DATA
  } am_state_t;
endpackage

// File: rtl/i2c_am_cond.sv
module i2c_am_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_comb begin
    scl_rise  = scl_i & ~scl_q;
    scl_fall  = ~scl_i & scl_q;
    start_det = scl_i & scl_q & sda_q & ~sda_i;
    stop_det  = scl_i & scl_q & ~sda_q & sda_i;
  end
endmodule

// File: rtl/i2c_am_shift.sv
module i2c_am_shift
  import i2c_am_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              abort,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_i,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_val,
  output logic              ack_open,
  output logic              ack_close
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);

  logic [BYTE_W-1:0] sr;
  logic [CNT_W-1:0]  cnt;
  logic              in_ack;

  always_comb begin
    byte_val  = {sr[BYTE_W-2:0], sda_i};
    byte_done = run & scl_rise & ~in_ack & (cnt == LAST_BIT);
    ack_open  = run & scl_fall & ~in_ack & (cnt == FULL_CNT);
    ack_close = run & scl_fall & in_ack;
  end

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      cnt    <= '0;
      in_ack <= 1'b0;
      if (rst) sr <= '0;
    end else if (run) begin
      if (scl_rise && !in_ack && cnt < FULL_CNT) begin
        sr  <= byte_val;
        cnt <= cnt + 1'b1;
      end
      if (ack_open) begin
        in_ack <= 1'b1;
      end else if (ack_close) begin
        in_ack <= 1'b0;
        cnt    <= '0;
      end
    end
  end
endmodule

// File: rtl/i2c_am_ctrl.sv
module i2c_am_ctrl
  import i2c_am_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] byte_val,
  input  logic              ack_open,
  input  logic              ack_close,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              addr_10bit,
  input  logic              gcall_en,
  input  logic              buf_rd,
  input  logic              ovf_clr,
  output logic              run,
  output logic              sda_pull,
  output logic [BYTE_W-1:0] rx_buf,
  output logic              buf_full,
  output logic              rx_ovf,
  output logic              irq,
  output logic              upd_addr,
  output logic              gcall_hit
);
  am_state_t st, nxt_st;
  logic      accept, gc_m, id_m, ack_d;

  always_comb begin
    gc_m   = 1'b0;
    id_m   = 1'b0;
    accept = 1'b0;
    nxt_st = ST_DATA;
    case (st)
      ST_ADDR1: begin
        gc_m = gcall_en && (byte_val == '0);
        if (addr_10bit)
          id_m = (byte_val == {TENBIT_HDR, own_addr[9:8], 1'b0});
        else
          id_m = (byte_val[BYTE_W-1:1] == own_addr[BYTE_W-2:0]);
        accept = gc_m | id_m;
        nxt_st = (addr_10bit && !gc_m) ? ST_ADDR2 : ST_DATA;
      end
      ST_ADDR2: accept = (byte_val == own_addr[BYTE_W-1:0]);
      ST_DATA:  accept = 1'b1;
      default:  accept = 1'b0;
    endcase
  end

  assign run = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      ack_d     <= 1'b0;
      sda_pull  <= 1'b0;
      rx_buf    <= '0;
      buf_full  <= 1'b0;
      rx_ovf    <= 1'b0;
      irq       <= 1'b0;
      upd_addr  <= 1'b0;
      gcall_hit <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (buf_rd)  buf_full <= 1'b0;
      if (ovf_clr) rx_ovf   <= 1'b0;
      if (start_det || stop_det) begin
        st        <= start_det ? ST_ADDR1 : ST_IDLE;
        ack_d     <= 1'b0;
        sda_pull  <= 1'b0;
        upd_addr  <= 1'b0;
        gcall_hit <= 1'b0;
      end else begin
        if (byte_done) begin
          ack_d <= accept && !buf_full;
          if (accept && buf_full) begin
            rx_ovf <= 1'b1;
            st     <= ST_IDLE;
          end else if (accept) begin
            rx_buf   <= byte_val;
            buf_full <= 1'b1;
            st       <= nxt_st;
          end else begin
            st <= ST_IDLE;
          end
          if (st == ST_ADDR2) upd_addr <= 1'b0;
          if (st == ST_ADDR1 && !buf_full) begin
            gcall_hit <= gc_m;
            upd_addr  <= id_m && !gc_m && addr_10bit;
          end
        end
        if (ack_open) sda_pull <= ack_d;
        if (ack_close) begin
          sda_pull <= 1'b0;
          irq      <= ack_d;
          ack_d    <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_am_top.sv
module i2c_am_top
  import i2c_am_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              addr_10bit,
  input  logic              gcall_en,
  input  logic              buf_rd,
  input  logic              ovf_clr,
  output logic              sda_pull,
  output logic [BYTE_W-1:0] rx_buf,
  output logic              buf_full,
  output logic              rx_ovf,
  output logic              irq,
  output logic              upd_addr,
  output logic              gcall_hit
);
  logic scl_rise, scl_fall, start_det, stop_det;
  logic run, byte_done, ack_open, ack_close;
  logic [BYTE_W-1:0] byte_val;

  i2c_am_cond u_cond (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_am_shift u_shift (
    .clk(clk), .rst(rst), .run(run), .abort(start_det | stop_det),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_i(sda_i),
    .byte_done(byte_done), .byte_val(byte_val),
    .ack_open(ack_open), .ack_close(ack_close)
  );

  i2c_am_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start_det(start_det), .stop_det(stop_det),
    .byte_done(byte_done), .byte_val(byte_val),
    .ack_open(ack_open), .ack_close(ack_close),
    .own_addr(own_addr), .addr_10bit(addr_10bit), .gcall_en(gcall_en),
    .buf_rd(buf_rd), .ovf_clr(ovf_clr), .run(run),
    .sda_pull(sda_pull), .rx_buf(rx_buf), .buf_full(buf_full),
    .rx_ovf(rx_ovf), .irq(irq), .upd_addr(upd_addr), .gcall_hit(gcall_hit)
  );
endmodule

// File: rtl/i2c_am_checker.sv
module i2c_am_checker (
  input logic       clk,
  input logic       rst,
  input logic       scl_i,
  input logic       sda_i,
  input logic       sda_pull,
  input logic [7:0] rx_buf,
  input logic       rx_ovf,
  input logic       irq,
  input logic       upd_addr,
  input logic       gcall_hit
);
  // R2: acknowledge drive only starts after SCL has been seen low
  a_r2_pull_after_low: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull) |-> $past(!scl_i));

  // R7: interrupt is a single-cycle pulse
  a_r7_irq_pulse: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  // R8: overflow never disturbs the buffered byte
  a_r8_ovf_keeps_buf: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_ovf) |-> $stable(rx_buf));

  // R5: general call never requests the second 10-bit byte
  a_r5_upd_excl_gc: assert property (@(posedge clk) disable iff (rst)
    !(upd_addr && gcall_hit));

  // R1: a Stop releases SDA and clears the transfer indications
  a_r1_stop_release: assert property (@(posedge clk) disable iff (rst)
    (scl_i && $past(scl_i) && sda_i && !$past(sda_i)) |=>
      (!sda_pull && !upd_addr && !gcall_hit));
endmodule

bind i2c_am_top i2c_am_checker u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
  .sda_pull(sda_pull), .rx_buf(rx_buf), .rx_ovf(rx_ovf), .irq(irq),
  .upd_addr(upd_addr), .gcall_hit(gcall_hit)
);

// File: tb/i2c_am_top_tb.sv
`timescale 1ns/1ps
module i2c_am_top_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl = 1'b1, sda = 1'b1;
  logic [9:0] own_addr = 10'h05A;
  logic       addr_10bit = 1'b0, gcall_en = 1'b0, buf_rd = 1'b0, ovf_clr = 1'b0;
  logic       sda_pull, buf_full, rx_ovf, irq, upd_addr, gcall_hit;
  logic [7:0] rx_buf;

  int checks = 0, errors = 0, irq_cnt = 0, irq_before;
  logic got_ack;

  always #2.5 clk = ~clk;
  always @(posedge clk) if (irq) irq_cnt <= irq_cnt + 1;

  i2c_am_top u_dut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda), .own_addr(own_addr),
    .addr_10bit(addr_10bit), .gcall_en(gcall_en), .buf_rd(buf_rd),
    .ovf_clr(ovf_clr), .sda_pull(sda_pull), .rx_buf(rx_buf),
    .buf_full(buf_full), .rx_ovf(rx_ovf), .irq(irq), .upd_addr(upd_addr),
    .gcall_hit(gcall_hit)
  );

  // {own[9:0], 10bit, gcall_en, byte[7:0], exp_ack, exp_upd, exp_gc}
  localparam int NV = 11;
  localparam logic [22:0] VECS [NV] = '{
    {10'h05A, 1'b0, 1'b0, 8'hB4, 3'b100},
    {10'h05A, 1'b0, 1'b0, 8'hB5, 3'b100},
    {10'h05A, 1'b0, 1'b0, 8'hB6, 3'b000},
    {10'h05A, 1'b0, 1'b1, 8'h00, 3'b101},
    {10'h05A, 1'b0, 1'b0, 8'h00, 3'b000},
    {10'h05A, 1'b0, 1'b1, 8'h01, 3'b000},
    {10'h2C3, 1'b1, 1'b0, 8'hF4, 3'b110},
    {10'h2C3, 1'b1, 1'b0, 8'hF5, 3'b000},
    {10'h2C3, 1'b1, 1'b0, 8'hF2, 3'b000},
    {10'h2C3, 1'b1, 1'b1, 8'h00, 3'b101},
    {10'h2C3, 1'b1, 1'b0, 8'h00, 3'b000}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda = 1'b1; tick(2); scl = 1'b1; tick(4); sda = 1'b0; tick(4); scl = 1'b0; tick(2);
  endtask

  task automatic bus_stop();
    scl = 1'b0; tick(2); sda = 1'b0; tick(2); scl = 1'b1; tick(4); sda = 1'b1; tick(4);
  endtask

  task automatic send_bit(input logic b);
    scl = 1'b0; tick(2); sda = b; tick(2); scl = 1'b1; tick(4); scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda = 1'b1; tick(2);
    got_ack = sda_pull;
    irq_before = irq_cnt;
    scl = 1'b1; tick(4); scl = 1'b0; tick(3);
  endtask

  task automatic read_buf();
    buf_rd = 1'b1; tick(1); buf_rd = 1'b0; tick(1);
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tick(2);
    // R11: reset state
    check("R11 outputs", {sda_pull, rx_buf, buf_full, rx_ovf, irq, upd_addr, gcall_hit}, '0);

    for (int v = 0; v < NV; v++) begin
      logic [7:0] b;
      own_addr = VECS[v][22:13]; addr_10bit = VECS[v][12]; gcall_en = VECS[v][11];
      b = VECS[v][10:3];
      bus_start();
      send_byte(b);
      check($sformatf("R2/R4/R10 ack vec%0d", v), got_ack, VECS[v][2]);
      check($sformatf("R4/R5 upd_addr vec%0d", v), upd_addr, VECS[v][1]);
      check($sformatf("R3 gcall_hit vec%0d", v), gcall_hit, VECS[v][0]);
      check($sformatf("R6 buf_full vec%0d", v), buf_full, VECS[v][2]);
      check($sformatf("R7 irq count vec%0d", v), irq_cnt - irq_before, VECS[v][2]);
      if (VECS[v][2]) check($sformatf("R6 rx_buf vec%0d", v), rx_buf, b);
      read_buf();
      check($sformatf("R6 buf_rd clears vec%0d", v), buf_full, 1'b0);
      bus_stop();
      check($sformatf("R1 stop releases vec%0d", v), {sda_pull, upd_addr, gcall_hit}, 3'b000);
    end

    // R4: full 10-bit address then data
    own_addr = 10'h2C3; addr_10bit = 1'b1; gcall_en = 1'b0;
    bus_start();
    send_byte(8'hF4);
    check("R4 header ack", {got_ack, upd_addr}, 2'b11);
    read_buf();
    send_byte(8'hC3);
    check("R4 low byte ack", {got_ack, upd_addr}, 2'b10);
    check("R4 low byte buffered", rx_buf, 8'hC3);
    read_buf();
    send_byte(8'h3C);
    check("R4 data ack", got_ack, 1'b1);
    check("R6 data buffered", rx_buf, 8'h3C);
    read_buf();
    bus_stop();

    // R4: wrong low address byte is refused
    bus_start();
    send_byte(8'hF4);
    read_buf();
    send_byte(8'hC4);
    check("R4 wrong low nack", {got_ack, upd_addr, buf_full}, 3'b000);
    bus_stop();

    // R5: 10-bit general call goes straight to data
    gcall_en = 1'b1;
    bus_start();
    send_byte(8'h00);
    check("R5 gc ack no upd", {got_ack, upd_addr, gcall_hit}, 3'b101);
    read_buf();
    send_byte(8'h77);
    check("R5 data after gc ack", got_ack, 1'b1);
    check("R5 data buffered", rx_buf, 8'h77);
    read_buf();
    bus_stop();

    // R8: overflow
    own_addr = 10'h05A; addr_10bit = 1'b0; gcall_en = 1'b0;
    bus_start();
    send_byte(8'hB4);
    read_buf();
    send_byte(8'h11);
    check("R8 first data ack", got_ack, 1'b1);
    send_byte(8'h22);
    check("R8 overflow nack", got_ack, 1'b0);
    check("R8 overflow flag", rx_ovf, 1'b1);
    check("R8 buffer kept", rx_buf, 8'h11);
    check("R8 no irq", irq_cnt - irq_before, 0);
    bus_stop();
    ovf_clr = 1'b1; tick(1); ovf_clr = 1'b0; tick(1);
    check("R8 ovf_clr", rx_ovf, 1'b0);
    read_buf();

    // R9: Start in mid-byte restarts address reception
    bus_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_start();
    send_byte(8'hB4);
    check("R9 mid-byte restart ack", got_ack, 1'b1);
    check("R9 restart buffered", rx_buf, 8'hB4);
    read_buf();
    // R9: repeated Start after a byte
    bus_start();
    send_byte(8'hB4);
    check("R9 repeated start ack", got_ack, 1'b1);
    read_buf();
    bus_stop();

    // R1: Stop in mid-byte, then clocks without a Start are ignored
    bus_start();
    send_bit(1'b1); send_bit(1'b0);
    bus_stop();
    send_byte(8'hB4);
    check("R1 idle ignores bus", {got_ack, buf_full}, 2'b00);
    check("R1 idle no irq", irq_cnt - irq_before, 0);

    // R10: nonmatching address then a would-be data byte
    bus_start();
    send_byte(8'hB6);
    send_byte(8'h55);
    check("R10 stays idle after miss", {got_ack, buf_full}, 2'b00);
    bus_stop();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule